// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits between the raw oscillator input of a small 8-bit controller and the clock gates of its internal domains. It halves the input clock to make a duty-cycle-independent internal clock. It then produces three enables: one gates the processor clock, one gates the peripheral and interrupt clock, and one keeps the oscillator pad running. Software selects the mode by writing a control byte.

Two sleep depths exist. In the shallow one only the processor clock stops, and any interrupt request resumes execution. In the deep one every enable drops, including the oscillator enable, and only a synchronous reset brings the block back. All enable changes are timed to the low half of the divided clock, so a downstream AND gate of the divided clock with an enable never produces a shortened pulse. The current committed mode and the control byte are both readable.

Top module: `lpc_clock_ctrl`

## Requirements
- R1: `divClk` is low while reset is held. It then toggles on every rising edge of `clk`, so the first edge after reset release drives it high.
- R2: A write on `wrEn` stores `wrData` in the control byte at the next `clk` edge, and the stored value is visible on `ctrlRd`. Bit 0 is the shallow-sleep request and bit 1 is the deep-sleep request. Other bits are stored as written. A write with both bit 0 and bit 1 set stores bit 1 only (bit 0 reads 0), so deep sleep wins.
- R3: The three enables change only at `clk` edges where `divClk` falls. A control-byte change made while `divClk` is high takes effect one full divided period later, not at the next edge.
- R4: With bit 0 set, from the next falling `divClk` edge on: `cpuClkEn`=0, `perClkEn`=1, `oscEn`=1 and `modeStatus`=1. Peripheral edges continue to be counted while processor edges stop.
- R5: With bit 1 set, from the next falling `divClk` edge on: all three enables are 0 and `modeStatus`=2. No domain sees an enabled divided-clock edge.
- R6: When bit 0 is set and bit 1 is clear, a one-cycle `irqReq` clears bit 0 at the next `clk` edge. `cpuClkEn` returns to 1 at the following falling `divClk` edge and `modeStatus` returns to 0.
- R7: `irqReq` has no effect on the control byte or the enables in run mode (`modeStatus`=0) or while bit 1 is set.
- R8: Writes are discarded while bit 0 or bit 1 of the stored control byte is set.
- R9: A synchronous reset clears the control byte except bit 4, which keeps its prior value. It also sets `modeStatus`=0, all enables to 1 and `divClk`=0, at the same edge.
- R10: Once bit 1 is set, it stays set until a reset. Neither interrupts nor writes clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Control byte write strobe |
| wrData | input | 8 | Control byte write value |
| irqReq | input | 1 | Interrupt request from the interrupt logic |
| divClk | output | 1 | Input clock divided by two |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral and interrupt clock enable |
| oscEn | output | 1 | Oscillator pad enable |
| modeStatus | output | 2 | Committed mode: 0 run, 1 shallow sleep, 2 deep sleep |
| ctrlRd | output | 8 | Current control byte |

## Verification
A write or interrupt changes `ctrlRd` one `clk` edge later. The enables and `modeStatus` follow at the first falling `divClk` edge after that: two edges after stimulus given in the low divided phase, three edges after stimulus given in the high phase. The bench aligns every stimulus to a known phase and queues each expected value for the exact edge count. It checks the intermediate edges as well, so an enable that moves early is caught. Edge counts per domain are collected over 20-edge windows, which span exactly ten rising divided-clock edges.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } lpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    lpMode_e tgtMode;
    logic    syncRst;
  } ctlStrobe_t;

endpackage

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int KEEP_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqReq,
  output logic [DATA_W-1:0] ctrlRd,
  output ctlStrobe_t        strobe
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << KEEP_BIT;
  localparam logic [DATA_W-1:0] IDLE_MASK = DATA_W'(1) << IDLE_BIT;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] wrFiltered;
  logic              sleepPending;
  logic              wakeIdle;

  assign sleepPending = ctrlReg[IDLE_BIT] | ctrlReg[PD_BIT];
  assign wakeIdle     = irqReq & ctrlReg[IDLE_BIT] & ~ctrlReg[PD_BIT];

  // deep sleep wins over shallow sleep in one write
  always_comb begin
    wrFiltered = wrData;
    if (wrData[PD_BIT]) wrFiltered = wrData & ~IDLE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= ctrlReg & KEEP_MASK;
    end else if (wrEn && !sleepPending) begin
      ctrlReg <= wrFiltered;
    end else if (wakeIdle) begin
      ctrlReg[IDLE_BIT] <= 1'b0;
    end
  end

  always_comb begin
    strobe.syncRst = rst;
    if (ctrlReg[PD_BIT])        strobe.tgtMode = MODE_PD;
    else if (ctrlReg[IDLE_BIT]) strobe.tgtMode = MODE_IDLE;
    else                        strobe.tgtMode = MODE_RUN;
  end

  assign ctrlRd = ctrlReg;

  // R10: deep-sleep bit only leaves through reset
  a_r10_pd_sticky: assert property (@(posedge clk) disable iff (rst)
    ctrlReg[PD_BIT] |=> ctrlReg[PD_BIT]);

  // R6: interrupt clears the shallow-sleep bit
  a_r6_irq_wake: assert property (@(posedge clk) disable iff (rst)
    (ctrlReg[IDLE_BIT] && !ctrlReg[PD_BIT] && irqReq) |=> !ctrlReg[IDLE_BIT]);

  // R8: writes while a sleep bit is set leave the byte alone
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (sleepPending && wrEn && !irqReq) |=> $stable(ctrlReg));

  // R2: both sleep bits written together keep deep sleep only
  a_r2_pd_priority: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !sleepPending && wrData[IDLE_BIT] && wrData[PD_BIT])
      |=> (ctrlReg[PD_BIT] && !ctrlReg[IDLE_BIT]));

endmodule

// File: rtl/lpc_dpath.sv
module lpc_dpath
  import lpc_pkg::*;
#(
  parameter int NUM_DOM = 3
) (
  input  logic         clk,
  input  ctlStrobe_t   strobe,
  output logic         divClk,
  output logic [NUM_DOM-1:0] domEn,
  output lpMode_e      modeQ
);

  localparam int CPU_IDX = 0;

  logic phase;

  // domain 0 runs only in run mode; the rest stop only in deep sleep
  function automatic logic domainOn(lpMode_e m, int d);
    if (d == CPU_IDX) return m == MODE_RUN;
    return m != MODE_PD;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.syncRst) begin
      phase <= 1'b0;
      modeQ <= MODE_RUN;
    end else begin
      phase <= ~phase;
      if (phase) modeQ <= strobe.tgtMode;
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (strobe.syncRst)  domEn[d] <= 1'b1;
      else if (phase)      domEn[d] <= domainOn(strobe.tgtMode, d);
    end
  end

  assign divClk = phase;

  // R1: divided clock alternates every raw edge
  a_r1_div_toggle: assert property (@(posedge clk) disable iff (strobe.syncRst)
    phase |=> !phase);

  // R3: enables move only when the divided clock falls
  a_r3_low_phase_update: assert property (@(posedge clk) disable iff (strobe.syncRst)
    !$stable(domEn) |-> ($past(phase) || $past(strobe.syncRst)));

  // R5: deep-sleep target drops every enable at the slot
  a_r5_pd_all_off: assert property (@(posedge clk) disable iff (strobe.syncRst)
    (phase && strobe.tgtMode == MODE_PD) |=> (domEn == '0));

  // R4: shallow-sleep target stops only the processor domain
  a_r4_idle_cpu_off: assert property (@(posedge clk) disable iff (strobe.syncRst)
    (phase && strobe.tgtMode == MODE_IDLE) |=> (!domEn[CPU_IDX] && domEn[NUM_DOM-1]));

endmodule

// File: rtl/lpc_clock_ctrl.sv
module lpc_clock_ctrl
  import lpc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int KEEP_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqReq,
  output logic              divClk,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              oscEn,
  output logic [1:0]        modeStatus,
  output logic [DATA_W-1:0] ctrlRd
);

  localparam int NUM_DOM = 3;

  ctlStrobe_t         strobe;
  logic [NUM_DOM-1:0] domEn;
  lpMode_e            modeQ;

  lpc_ctrl #(
    .DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT), .PD_BIT(PD_BIT), .KEEP_BIT(KEEP_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .irqReq(irqReq),
    .ctrlRd(ctrlRd), .strobe(strobe)
  );

  lpc_dpath #(.NUM_DOM(NUM_DOM)) u_dpath (
    .clk(clk), .strobe(strobe), .divClk(divClk), .domEn(domEn), .modeQ(modeQ)
  );

  assign cpuClkEn   = domEn[0];
  assign perClkEn   = domEn[1];
  assign oscEn      = domEn[2];
  assign modeStatus = modeQ;

endmodule

// File: tb/lpc_clock_ctrl_bench.sv
module lpc_clock_ctrl_bench;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic irqReq = 1'b0;
  logic divClk, cpuClkEn, perClkEn, oscEn;
  logic [1:0] modeStatus;
  logic [7:0] ctrlRd;

  lpc_clock_ctrl u_lpc_clock_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .irqReq(irqReq),
    .divClk(divClk), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .oscEn(oscEn),
    .modeStatus(modeStatus), .ctrlRd(ctrlRd)
  );

  always #(CLK_P/2) clk = ~clk;

  // enabled divided-clock edges per domain
  int cpuEdges = 0, perEdges = 0, oscEdges = 0;
  always @(posedge divClk) begin
    if (cpuClkEn) cpuEdges++;
    if (perClkEn) perEdges++;
    if (oscEn)    oscEdges++;
  end

  typedef enum int {S_CTRL, S_MODE, S_EN, S_DIV, S_CPUCNT, S_PERCNT, S_OSCCNT} sel_e;
  typedef struct {
    sel_e        sel;
    logic [31:0] exp;
    logic [31:0] mask;
    string       req;
  } item_t;

  item_t q[$];
  int nCmp = 0, nBad = 0;
  bit done = 0;

  task automatic expect_val(sel_e s, logic [31:0] e, string r, logic [31:0] m = 32'hFFFF_FFFF);
    item_t it;
    it.sel = s; it.exp = e; it.mask = m; it.req = r;
    q.push_back(it);
  endtask

  function automatic logic [31:0] observe(sel_e s);
    case (s)
      S_CTRL:   return {24'd0, ctrlRd};
      S_MODE:   return {30'd0, modeStatus};
      S_EN:     return {29'd0, cpuClkEn, perClkEn, oscEn};
      S_DIV:    return {31'd0, divClk};
      S_CPUCNT: return cpuEdges;
      S_PERCNT: return perEdges;
      default:  return oscEdges;
    endcase
  endfunction

  // monitor: compares queued expectations at the falling raw edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = observe(it.sel);
        nCmp++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          nBad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel,
                   act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic alignLow();
    while (divClk !== 1'b0) step(1);
  endtask

  task automatic wr(logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    step(1);
    wrEn = 1'b0;
  endtask

  int c0, p0, o0;
  task automatic snap();
    c0 = cpuEdges; p0 = perEdges; o0 = oscEdges;
  endtask

  initial begin
    step(3);
    // R9: first reset, bit 4 has no prior value so it is masked
    expect_val(S_CTRL, 32'h00, "R9", 32'hEF);
    expect_val(S_MODE, 0, "R9");
    expect_val(S_EN, 3'b111, "R9");
    expect_val(S_DIV, 0, "R1");
    rst = 1'b0;
    step(1); expect_val(S_DIV, 1, "R1");
    step(1); expect_val(S_DIV, 0, "R1");

    // R2: plain write
    wr(8'h50); expect_val(S_CTRL, 8'h50, "R2");
    step(1);
    alignLow();

    // R4: shallow sleep, enables follow at the next falling divClk
    wr(8'h51);
    expect_val(S_CTRL, 8'h51, "R2");
    expect_val(S_EN, 3'b111, "R3");
    step(1);
    expect_val(S_EN, 3'b011, "R4");
    expect_val(S_MODE, 1, "R4");
    snap(); step(20);
    expect_val(S_CPUCNT, c0, "R4");
    expect_val(S_PERCNT, p0 + 10, "R4");
    expect_val(S_OSCCNT, o0 + 10, "R4");

    // R8: write discarded in shallow sleep
    wr(8'h50); expect_val(S_CTRL, 8'h51, "R8");
    step(1); expect_val(S_EN, 3'b011, "R8");
    alignLow();

    // R6: interrupt wake
    irqReq = 1'b1; step(1); irqReq = 1'b0;
    expect_val(S_CTRL, 8'h50, "R6");
    expect_val(S_EN, 3'b011, "R6");
    step(1);
    expect_val(S_EN, 3'b111, "R6");
    expect_val(S_MODE, 0, "R6");
    snap(); step(20);
    expect_val(S_CPUCNT, c0 + 10, "R6");

    // R7: interrupt in run mode has no effect
    irqReq = 1'b1; step(2); irqReq = 1'b0;
    expect_val(S_CTRL, 8'h50, "R7");
    expect_val(S_EN, 3'b111, "R7");
    step(1);
    expect_val(S_EN, 3'b111, "R7");

    // R3/R5: deep-sleep write in the high phase takes three edges
    alignLow(); step(1);
    wr(8'h12);
    expect_val(S_CTRL, 8'h12, "R2");
    expect_val(S_EN, 3'b111, "R3");
    step(1); expect_val(S_EN, 3'b111, "R3");
    step(1);
    expect_val(S_EN, 3'b000, "R5");
    expect_val(S_MODE, 2, "R5");

    // R7/R10: interrupts do not wake deep sleep
    irqReq = 1'b1; step(4); irqReq = 1'b0;
    expect_val(S_EN, 3'b000, "R10");
    expect_val(S_CTRL, 8'h12, "R7");
    // R8/R10: write cannot leave deep sleep
    wr(8'h00); step(1);
    expect_val(S_CTRL, 8'h12, "R10");
    expect_val(S_MODE, 2, "R10");
    snap(); step(20);
    expect_val(S_CPUCNT, c0, "R5");
    expect_val(S_PERCNT, p0, "R5");
    expect_val(S_OSCCNT, o0, "R5");

    // R9: reset keeps bit 4 only
    rst = 1'b1; step(1);
    expect_val(S_CTRL, 8'h10, "R9");
    expect_val(S_MODE, 0, "R9");
    expect_val(S_EN, 3'b111, "R9");
    expect_val(S_DIV, 0, "R9");
    rst = 1'b0;
    step(1); expect_val(S_DIV, 1, "R1");
    step(1);

    // R2: both sleep bits together, deep sleep wins
    wr(8'h03);
    expect_val(S_CTRL, 8'h02, "R2");
    step(1);
    expect_val(S_EN, 3'b000, "R2");
    expect_val(S_MODE, 2, "R2");
    rst = 1'b1; step(1);
    expect_val(S_CTRL, 8'h00, "R9");
    expect_val(S_EN, 3'b111, "R9");
    rst = 1'b0;

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule